// File: doc/BRIEF.md
# Fixed-Slot Message Queue Manager

This block keeps a set of fixed-length text messages in an on-chip byte memory that is split into equal slots. A slot counts as empty when its first byte is zero. Occupied slots always sit packed at the front of the memory, so the first empty slot is the tail of the queue. The block reports the tail position, the number of stored messages and a full flag, and it serves four commands through one port: create a message, delete a message, overwrite one byte, and read one byte.

Creating a message claims the tail slot and fills it with spaces. Deleting a message keeps the queue packed: the last occupied message is copied into the freed slot and the last slot is then cleared. The final slot of the memory is never handed out, so it always stays empty and ends the queue. A multi-cycle command raises `busy_o` until it finishes, and every command ends with a single-cycle `done_o`. `err_o` is raised together with `done_o` when a command is rejected.

Top module: `msgq_mgr`

## Requirements
- R1: After reset every byte of every slot reads 0x00, count_o and tail_o are 0, and full_o, busy_o, done_o and err_o are low.
- R2: Command code 0 (new), when not full, fills the slot at the tail with 0x20 in all SLOT_BYTES bytes, one byte per cycle. busy_o is high for SLOT_BYTES cycles starting the cycle after acceptance. done_o pulses for one cycle right after busy_o falls, with new_slot_o holding the index of the filled slot.
- R3: full_o is high exactly when count_o equals NUM_SLOTS-1. The last slot is never written and always reads 0x00. A new command while full completes with done_o and err_o one cycle after acceptance and changes nothing.
- R4: Occupied slots always form a packed prefix. tail_o is the lowest slot whose first byte is 0x00, and count_o equals tail_o.
- R5: Command code 1 (delete) on an occupied slot d that is not the last occupied slot L first copies the 16 bytes of L into d, then fills L with 0x00. busy_o is high for 2*SLOT_BYTES cycles.
- R6: A delete of the last occupied slot skips the copy. It only fills that slot with 0x00, with busy_o high for SLOT_BYTES cycles.
- R7: A delete on an empty queue, or on a slot at or above count_o, completes with done_o and err_o one cycle after acceptance and changes nothing.
- R8: Command code 2 (write) stores cmd_wdata_i at byte cmd_idx_i of slot cmd_slot_i and finishes one cycle after acceptance without raising busy_o. It is rejected with err_o, and nothing changes, when the slot is not occupied or when it would write 0x00 to byte 0.
- R9: Command code 3 (read) returns the addressed byte on rdata_o in the cycle done_o is high, one cycle after acceptance, for any slot.
- R10: cmd_valid_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request, accepted when busy_o is low |
| cmd_op_i | input | 2 | 0 new, 1 delete, 2 write byte, 3 read byte |
| cmd_slot_i | input | $clog2(NUM_SLOTS) | Slot operand |
| cmd_idx_i | input | $clog2(SLOT_BYTES) | Byte index within the slot |
| cmd_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Multi-cycle command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Command rejected, valid with done_o |
| rdata_o | output | 8 | Byte returned by a read |
| new_slot_o | output | $clog2(NUM_SLOTS) | Slot claimed by the last new command |
| tail_o | output | $clog2(NUM_SLOTS) | First empty slot |
| count_o | output | $clog2(NUM_SLOTS) | Number of stored messages |
| full_o | output | 1 | Queue holds NUM_SLOTS-1 messages |

## Verification
The bench builds the block with its default parameters: 32 slots of 16 bytes. With these values the queue can be filled to its 31-message limit in a few hundred cycles, so the rejected create, the untouched terminator slot and a delete on a full queue can all be reached. It also exercises both delete paths, the copy-then-clear path and the clear-only path, so the 32-cycle and 16-cycle busy windows are each checked against the model. A full read-back of all 512 bytes at the end compares every byte against the model.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  typedef enum logic [1:0] {
    OP_NEW = 2'd0,
    OP_DEL = 2'd1,
    OP_WR  = 2'd2,
    OP_RD  = 2'd3
  } msgq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_COPY
  } msgq_state_e;

  localparam logic [7:0] SPACE_CHAR = 8'h20;
  localparam logic [7:0] NUL_CHAR   = 8'h00;
endpackage

// File: rtl/msgq_store.sv
module msgq_store #(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BYTES = 16,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int IW = $clog2(SLOT_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [SW-1:0]        wslot_i,
  input  logic [IW-1:0]        widx_i,
  input  logic [7:0]           wdata_i,
  input  logic [SW-1:0]        rslot_i,
  input  logic [IW-1:0]        ridx_i,
  output logic [7:0]           rdata_o,
  output logic [NUM_SLOTS-1:0] head_nz_o
);
  localparam int LAST_SLOT = NUM_SLOTS - 1;

  logic [7:0] mem [NUM_SLOTS][SLOT_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int b = 0; b < SLOT_BYTES; b++)
          mem[s][b] <= '0;
    end else if (we_i) begin
      mem[wslot_i][widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[rslot_i][ridx_i];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_head
    assign head_nz_o[g] = |mem[g][0];
  end

  AST_TERM_SLOT_NUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem[LAST_SLOT][0] == 8'h00); // R3
  AST_NO_WRITE_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wslot_i != SW'(LAST_SLOT))); // R3
endmodule

// File: rtl/msgq_tail.sv
module msgq_tail #(
  parameter int NUM_SLOTS = 32,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] head_nz_i,
  output logic [SW-1:0]        tail_o,
  output logic                 full_o
);
  localparam int LAST_SLOT = NUM_SLOTS - 1;

  // lowest slot with a NUL head wins
  always_comb begin
    tail_o = SW'(LAST_SLOT);
    for (int i = LAST_SLOT; i >= 0; i--)
      if (!head_nz_i[i]) tail_o = SW'(i);
  end

  assign full_o = (tail_o == SW'(LAST_SLOT));
endmodule

// File: rtl/msgq_seq.sv
module msgq_seq
  import msgq_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BYTES = 16,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int IW = $clog2(SLOT_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  msgq_op_e      cmd_op_i,
  input  logic [SW-1:0] cmd_slot_i,
  input  logic [IW-1:0] cmd_idx_i,
  input  logic [7:0]    cmd_wdata_i,
  input  logic [SW-1:0] count_i,
  input  logic          full_i,
  input  logic [7:0]    rd_data_i,
  output logic          we_o,
  output logic [SW-1:0] wslot_o,
  output logic [IW-1:0] widx_o,
  output logic [7:0]    wdata_o,
  output logic [SW-1:0] rslot_o,
  output logic [IW-1:0] ridx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [7:0]    rdata_o,
  output logic [SW-1:0] new_slot_o
);
  localparam int LAST_IDX = SLOT_BYTES - 1;

  msgq_state_e state_q;
  logic [IW-1:0] cnt_q;
  logic [SW-1:0] dst_q, src_q;
  logic [7:0]    fill_q;

  logic accept, wr_ok, del_bad;
  assign accept  = cmd_valid_i && (state_q == ST_IDLE);
  assign wr_ok   = (cmd_slot_i < count_i) && !((cmd_idx_i == '0) && (cmd_wdata_i == NUL_CHAR));
  assign del_bad = (count_i == '0) || (cmd_slot_i >= count_i);
  assign busy_o  = (state_q != ST_IDLE);

  always_comb begin
    we_o    = 1'b0;
    wslot_o = dst_q;
    widx_o  = cnt_q;
    wdata_o = fill_q;
    rslot_o = cmd_slot_i;
    ridx_o  = cmd_idx_i;
    unique case (state_q)
      ST_FILL: we_o = 1'b1;
      ST_COPY: begin
        we_o    = 1'b1;
        rslot_o = src_q;
        ridx_o  = cnt_q;
        wdata_o = rd_data_i;
      end
      default: begin
        we_o    = accept && (cmd_op_i == OP_WR) && wr_ok;
        wslot_o = cmd_slot_i;
        widx_o  = cmd_idx_i;
        wdata_o = cmd_wdata_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      dst_q      <= '0;
      src_q      <= '0;
      fill_q     <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      rdata_o    <= '0;
      new_slot_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          done_o <= 1'b0;
          err_o  <= 1'b0;
          cnt_q  <= '0;
          if (accept) begin
            unique case (cmd_op_i)
              OP_NEW: if (full_i) begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
              end else begin
                state_q    <= ST_FILL;
                dst_q      <= count_i;
                fill_q     <= SPACE_CHAR;
                new_slot_o <= count_i;
              end
              OP_DEL: if (del_bad) begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
              end else if (cmd_slot_i == count_i - 1'b1) begin
                state_q <= ST_FILL;
                dst_q   <= cmd_slot_i;
                fill_q  <= NUL_CHAR;
              end else begin
                state_q <= ST_COPY;
                dst_q   <= cmd_slot_i;
                src_q   <= count_i - 1'b1;
              end
              OP_WR: begin
                done_o <= 1'b1;
                err_o  <= !wr_ok;
              end
              default: begin
                done_o  <= 1'b1;
                rdata_o <= rd_data_i;
              end
            endcase
          end
        end
        ST_FILL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == IW'(LAST_IDX)) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == IW'(LAST_IDX)) begin
            state_q <= ST_FILL;
            dst_q   <= src_q;
            fill_q  <= NUL_CHAR;
          end
        end
      endcase
    end
  end

  AST_FULL_NEW_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_op_i == OP_NEW && full_i) |=> (done_o && err_o)); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R7
  AST_BUSY_HOLDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(new_slot_o)); // R10
endmodule

// File: rtl/msgq_mgr.sv
module msgq_mgr
  import msgq_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BYTES = 16,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int IW = $clog2(SLOT_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [SW-1:0] cmd_slot_i,
  input  logic [IW-1:0] cmd_idx_i,
  input  logic [7:0]    cmd_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [7:0]    rdata_o,
  output logic [SW-1:0] new_slot_o,
  output logic [SW-1:0] tail_o,
  output logic [SW-1:0] count_o,
  output logic          full_o
);
  logic                 we;
  logic [SW-1:0]        wslot, rslot;
  logic [IW-1:0]        widx, ridx;
  logic [7:0]           wdata, rd_data;
  logic [NUM_SLOTS-1:0] head_nz;

  msgq_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) store_i (
    .clk_i, .rst_ni,
    .we_i(we), .wslot_i(wslot), .widx_i(widx), .wdata_i(wdata),
    .rslot_i(rslot), .ridx_i(ridx), .rdata_o(rd_data),
    .head_nz_o(head_nz)
  );

  msgq_tail #(.NUM_SLOTS(NUM_SLOTS)) tail_i (
    .head_nz_i(head_nz), .tail_o(tail_o), .full_o(full_o)
  );

  assign count_o = tail_o;

  msgq_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) seq_i (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_op_i(msgq_op_e'(cmd_op_i)),
    .cmd_slot_i, .cmd_idx_i, .cmd_wdata_i,
    .count_i(tail_o), .full_i(full_o), .rd_data_i(rd_data),
    .we_o(we), .wslot_o(wslot), .widx_o(widx), .wdata_o(wdata),
    .rslot_o(rslot), .ridx_o(ridx),
    .busy_o, .done_o, .err_o, .rdata_o, .new_slot_o
  );

  AST_PACKED_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(head_nz) == int'(count_o)); // R4
endmodule

// File: tb/msgq_mgr_tb.sv
module msgq_mgr_tb_top;
  localparam int NS = 32;
  localparam int NB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [4:0] cmd_slot = '0;
  logic [3:0] cmd_idx = '0;
  logic [7:0] cmd_wdata = '0;
  logic       busy, done, err, full;
  logic [7:0] rdata;
  logic [4:0] new_slot, tail, count;

  int checks = 0;
  int errors = 0;
  int mm [NS][NB];

  always #10 clk = ~clk;

  msgq_mgr #(.NUM_SLOTS(NS), .SLOT_BYTES(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_slot_i(cmd_slot),
    .cmd_idx_i(cmd_idx), .cmd_wdata_i(cmd_wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .new_slot_o(new_slot), .tail_o(tail), .count_o(count), .full_o(full)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int m_count();
    for (int i = 0; i < NS; i++)
      if (mm[i][0] == 0) return i;
    return NS - 1;
  endfunction

  task automatic check_state();
    int c = m_count();
    chk("R4 tail", int'(tail), c);
    chk("R4 count", int'(count), c);
    chk("R3 full", int'(full), int'(c == NS - 1));
  endtask

  // issue one command, then compare busy/done/err on every cycle to the model
  task automatic run_cmd(int op, int slot, int idx, int data, bit poke = 1'b0);
    int c = m_count();
    int lat = 0;
    bit e = 1'b0;
    string tag = "R9";
    case (op)
      0: begin e = (c == NS - 1); lat = e ? 0 : NB; tag = e ? "R3" : "R2"; end
      1: begin
        e = (c == 0) || (slot >= c);
        lat = e ? 0 : ((slot == c - 1) ? NB : 2 * NB);
        tag = e ? "R7" : ((slot == c - 1) ? "R6" : "R5");
      end
      2: begin e = (slot >= c) || (idx == 0 && data == 0); tag = "R8"; end
      default: tag = "R9";
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_slot = 5'(slot);
    cmd_idx = 4'(idx); cmd_wdata = 8'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int j = 0; j < lat; j++) begin
      chk({tag, " busy"}, int'(busy), 1);
      chk({tag, " done early"}, int'(done), 0);
      if (poke && j == 2) begin
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_slot = 5'd0;
        cmd_idx = 4'd5; cmd_wdata = 8'h41;
      end
      if (poke && j == 3) cmd_valid = 1'b0;
      @(negedge clk);
    end
    chk({tag, " busy end"}, int'(busy), 0);
    chk({tag, " done"}, int'(done), 1);
    chk({tag, " err"}, int'(err), int'(e));
    if (!e) begin
      case (op)
        0: begin
          chk("R2 new_slot", int'(new_slot), c);
          for (int b = 0; b < NB; b++) mm[c][b] = 32'h20;
        end
        1: begin
          if (slot != c - 1)
            for (int b = 0; b < NB; b++) mm[slot][b] = mm[c - 1][b];
          for (int b = 0; b < NB; b++) mm[c - 1][b] = 0;
        end
        2: mm[slot][idx] = data;
        default: chk("R9 rdata", int'(rdata), mm[slot][idx]);
      endcase
    end
    check_state();
  endtask

  task automatic check_all();
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < NB; b++)
        run_cmd(3, s, b, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < NB; b++) mm[s][b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 tail", int'(tail), 0);
    chk("R1 full", int'(full), 0);
    run_cmd(3, 0, 0, 0);            // R1 empty after reset
    run_cmd(3, 31, 15, 0);          // R1
    run_cmd(1, 0, 0, 0);            // R7 delete on empty
    run_cmd(2, 0, 3, 8'h48);        // R8 write to empty slot
    run_cmd(0, 0, 0, 0, 1'b1);      // R2 new + R10 poke ignored
    run_cmd(3, 0, 5, 0);            // R10 poke had no effect
    run_cmd(3, 0, 15, 0);           // R2
    run_cmd(2, 0, 3, 8'h48);        // R8
    run_cmd(2, 0, 0, 0);            // R8 NUL head rejected
    run_cmd(3, 0, 0, 0);            // R8
    run_cmd(0, 0, 0, 0);            // R2
    run_cmd(0, 0, 0, 0);            // R2
    run_cmd(2, 2, 0, 8'h43);
    run_cmd(2, 2, 9, 8'h7a);
    run_cmd(2, 1, 0, 8'h42);
    run_cmd(1, 0, 0, 0);            // R5 copy slot 2 into 0
    run_cmd(3, 0, 0, 0);            // R5
    run_cmd(3, 0, 9, 0);            // R5
    run_cmd(3, 2, 0, 0);            // R5 cleared
    run_cmd(1, 1, 0, 0);            // R6 last occupied
    run_cmd(1, 5, 0, 0);            // R7 beyond count
    while (m_count() < NS - 1) run_cmd(0, 0, 0, 0);
    run_cmd(0, 0, 0, 0);            // R3 new while full
    run_cmd(3, 31, 0, 0);           // R3 terminator stays NUL
    run_cmd(2, 30, 7, 8'h55);
    run_cmd(1, 0, 0, 0);            // R5 delete on full queue
    run_cmd(0, 0, 0, 0);            // R2 refill slot 30
    check_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule